// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel programmable interval timer. A two-bit address selects either one of three channel data ports or a write-only control port. The block decodes control words that configure a channel, freeze its count, or take a snapshot of several channels at once. It assembles one-byte and two-byte initial counts and hands each finished value to its channel with a one-cycle load pulse. On reads it returns a held status byte, a held count, or the live count, in that order of precedence.

The counting engines sit outside this block. Each channel's engine receives the load pulse, the 16-bit initial value, the mode and the BCD flag. It returns its live count and output level. The host issues at most one access per cycle, and a read and a write never happen in the same cycle. Read data is combinational from the address and the current state. The side effects of a read, such as releasing a latch or advancing the byte sequence, take effect at the clock edge that ends the read cycle.

Top module: `itmr_bus_regs`

## Requirements
- R1: A read at address 3 returns 0x00. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2.
- R2: A write at address 3 with bits 7:6 equal to a channel number and bits 5:4 non-zero configures that channel. Bits 5:4 are the access type (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 are the mode and bit 0 is the BCD flag. The mode and BCD outputs follow from the next cycle, and the other channels are unchanged.
- R3: With access type 1, a data write loads {8'h00, byte}. The load pulse is high for exactly the one cycle after the write.
- R4: With access type 2, a data write loads {byte, 8'h00}.
- R5: With access type 3, the first data write gives no load pulse. The second write loads {second, first}.
- R6: With no latch held, a data read returns the live count. It returns the low byte for type 1 and the high byte for type 2. For type 3 it returns low and high bytes alternately, starting with the low byte.
- R7: A control write with bits 5:4 = 0 latches the selected channel's count. Reads then return the latched value and release the latch afterwards: one byte for a type 1 or type 2 latch, and low then high for a type 3 latch. After release, reads return the live count again.
- R8: A count latch or status latch that is already held is not overwritten by a later latch command until it has been read out.
- R9: The status byte is {OUT, 1'b0, access type[1:0], mode[2:0], BCD}. A held status byte is returned before a held count and is released after a single read.
- R10: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches the status of every selected channel. Unselected channels are unaffected.
- R11: A configuring control write restarts that channel's write and read byte sequencing at the low byte.
- R12: After reset, every channel uses access type 3 with mode 0 and BCD 0. No latch is held and no load pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one byte per cycle |
| bus_rd | input | 1 | Host read strobe, one byte per cycle |
| bus_addr | input | 2 | 0 to 2 select a channel data port, 3 selects the control port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ch_load | output | 3 | Per-channel single-cycle load pulse |
| ch_load_val | output | 48 | Per-channel 16-bit initial value, channel i at bits 16i+15:16i |
| ch_mode | output | 9 | Per-channel 3-bit mode, channel i at bits 3i+2:3i |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_count | input | 48 | Per-channel live count from the engines |
| ch_out | input | 3 | Per-channel output level from the engines |

## Verification
The assertions check on every cycle the properties that involve only the ports. A control-port read returns zero. Load pulses are one-hot across channels. Each pulse follows a data write to its own channel. The mode outputs stay stable unless the control port is written. The properties that depend on history can only be shown by the bench's scenarios. These include the byte-pair assembly, alternating live reads, freezing and release of latches, the rule that a held latch is not overwritten, status-before-count priority, the multi-channel selection of read-back, and the restart of byte sequencing on reconfiguration. The bench sweeps every channel against every access type and every mode value.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int NUM_CH  = 3;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int MODE_W  = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    // control-port byte layout; the field positions are decoded by the host
    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

    // per-channel command produced by the control decoder
    typedef struct packed {
        logic              cfg_we;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              cnt_snap;
        logic              sts_snap;
    } ch_cmd_t;

    function automatic logic [BYTE_W-1:0] status_byte(
        input logic              out_lvl,
        input acc_e              acc,
        input logic [MODE_W-1:0] mode,
        input logic              bcd
    );
        return {out_lvl, 1'b0, acc, mode, bcd};
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(
        input logic [CNT_W-1:0] val,
        input logic             hi
    );
        return hi ? val[CNT_W-1:BYTE_W] : val[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/itmr_ctl_decode.sv
module itmr_ctl_decode
    import itmr_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] wdata,
    output ch_cmd_t           cmd [N_CH]
);

    ctl_word_t cw;
    assign cw = ctl_word_t'(wdata);

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            cmd[i] = '0;
            if (ctl_we) begin
                if (cw.sel == 2'b11) begin
                    // snapshot command: bit i+1 selects channel i
                    if (wdata[i+1]) begin
                        cmd[i].cnt_snap = ~wdata[5];
                        cmd[i].sts_snap = ~wdata[4];
                    end
                end else if (cw.sel == 2'(i)) begin
                    if (cw.acc == ACC_LATCH) begin
                        cmd[i].cnt_snap = 1'b1;
                    end else begin
                        cmd[i].cfg_we = 1'b1;
                        cmd[i].acc    = cw.acc;
                        cmd[i].mode   = cw.mode;
                        cmd[i].bcd    = cw.bcd;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/itmr_chan_regs.sv
module itmr_chan_regs
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_cmd_t           cmd,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              live_out,
    output logic [BYTE_W-1:0] rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);

    acc_e              acc;
    logic              wr_hi;
    logic              rd_hi;
    logic [BYTE_W-1:0] lo_hold;

    logic              cl_v;
    acc_e              cl_acc;
    logic              cl_hi;
    logic [CNT_W-1:0]  cl_val;

    logic              st_v;
    logic [BYTE_W-1:0] st_val;

    // read data: held status, then held count, then live count
    always_comb begin
        if (st_v) begin
            rdata = st_val;
        end else if (cl_v) begin
            unique case (cl_acc)
                ACC_LO:  rdata = pick_byte(cl_val, 1'b0);
                ACC_HI:  rdata = pick_byte(cl_val, 1'b1);
                default: rdata = pick_byte(cl_val, cl_hi);
            endcase
        end else begin
            unique case (acc)
                ACC_LO:  rdata = pick_byte(live, 1'b0);
                ACC_HI:  rdata = pick_byte(live, 1'b1);
                default: rdata = pick_byte(live, rd_hi);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= ACC_WORD;
            mode     <= '0;
            bcd      <= 1'b0;
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            lo_hold  <= '0;
            cl_v     <= 1'b0;
            cl_acc   <= ACC_WORD;
            cl_hi    <= 1'b0;
            cl_val   <= '0;
            st_v     <= 1'b0;
            st_val   <= '0;
            load     <= 1'b0;
            load_val <= '0;
        end else begin
            load <= 1'b0;

            if (cmd.cfg_we) begin
                acc   <= cmd.acc;
                mode  <= cmd.mode;
                bcd   <= cmd.bcd;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end

            if (cmd.cnt_snap && !cl_v) begin
                cl_v   <= 1'b1;
                cl_val <= live;
                cl_acc <= acc;
                cl_hi  <= 1'b0;
            end

            if (cmd.sts_snap && !st_v) begin
                st_v   <= 1'b1;
                st_val <= status_byte(live_out, acc, mode, bcd);
            end

            if (data_we) begin
                unique case (acc)
                    ACC_LO: begin
                        load     <= 1'b1;
                        load_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load     <= 1'b1;
                        load_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    default: begin
                        if (wr_hi) begin
                            load     <= 1'b1;
                            load_val <= {wdata, lo_hold};
                            wr_hi    <= 1'b0;
                        end else begin
                            lo_hold  <= wdata;
                            wr_hi    <= 1'b1;
                        end
                    end
                endcase
            end

            if (data_re) begin
                if (st_v) begin
                    st_v <= 1'b0;
                end else if (cl_v) begin
                    if (cl_acc == ACC_WORD && !cl_hi) cl_hi <= 1'b1;
                    else                              cl_v  <= 1'b0;
                end else if (acc == ACC_WORD) begin
                    rd_hi <= ~rd_hi;
                end
            end
        end
    end

endmodule

// File: rtl/itmr_bus_regs.sv
module itmr_bus_regs
    import itmr_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output logic [BYTE_W-1:0]       bus_rdata,
    output logic [N_CH-1:0]         ch_load,
    output logic [N_CH*CNT_W-1:0]   ch_load_val,
    output logic [N_CH*MODE_W-1:0]  ch_mode,
    output logic [N_CH-1:0]         ch_bcd,
    input  logic [N_CH*CNT_W-1:0]   ch_count,
    input  logic [N_CH-1:0]         ch_out
);

    localparam logic [1:0] CTL_ADDR = 2'd3;

    ch_cmd_t           cmd   [N_CH];
    logic [BYTE_W-1:0] ch_rd [N_CH];
    logic              ctl_we;

    assign ctl_we = bus_wr && (bus_addr == CTL_ADDR);

    itmr_ctl_decode #(.N_CH(N_CH)) u_dec (
        .ctl_we (ctl_we),
        .wdata  (bus_wdata),
        .cmd    (cmd)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        itmr_chan_regs u_ch (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[g]),
            .data_we  (bus_wr && (bus_addr == 2'(g))),
            .data_re  (bus_rd && (bus_addr == 2'(g))),
            .wdata    (bus_wdata),
            .live     (ch_count[g*CNT_W +: CNT_W]),
            .live_out (ch_out[g]),
            .rdata    (ch_rd[g]),
            .load     (ch_load[g]),
            .load_val (ch_load_val[g*CNT_W +: CNT_W]),
            .mode     (ch_mode[g*MODE_W +: MODE_W]),
            .bcd      (ch_bcd[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == 2'(i)) bus_rdata = ch_rd[i];
        end
    end

endmodule

// File: rtl/itmr_bus_regs_chk.sv
module itmr_bus_regs_chk
    import itmr_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [1:0]             bus_addr,
    input logic [BYTE_W-1:0]      bus_rdata,
    input logic [N_CH-1:0]        ch_load,
    input logic [N_CH*MODE_W-1:0] ch_mode
);

    // R1: the control port reads as zero
    p_ctl_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == '0));

    // R3: at most one channel receives a load pulse in any cycle
    p_load_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load));

    // R2: mode outputs only change after a control-port write
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 2'd3) |=> $stable(ch_mode));

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R5: a load pulse always follows a data write to the same channel
        p_load_after_wr_r5: assert property (@(posedge clk) disable iff (rst)
            ch_load[g] |-> $past(bus_wr && bus_addr == 2'(g)));
    end

endmodule

bind itmr_bus_regs itmr_bus_regs_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/test_itmr_bus_regs.sv
`timescale 1ns/1ps
module test_itmr_bus_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [2:0]  ch_load;
    logic [47:0] ch_load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [15:0] live [3];
    logic [2:0]  ch_out = 3'b000;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [2:0]  seen_load;
    logic [47:0] seen_val;

    always #4 clk = ~clk;

    itmr_bus_regs i_itmr_bus_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_load(ch_load), .ch_load_val(ch_load_val), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ch_count({live[2], live[1], live[0]}), .ch_out(ch_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        seen_load = ch_load;
        seen_val  = ch_load_val;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ctl(input int ch, input int acc, input int mode, input bit bcd);
        wr(2'd3, 8'((ch << 6) | (acc << 4) | (mode << 1) | int'(bcd)));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        live[0] = 16'h0; live[1] = 16'hA55A; live[2] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset defaults
        chk("R12 mode", 32'(ch_mode), 0);
        chk("R12 bcd", 32'(ch_bcd), 0);
        chk("R12 load", 32'(ch_load), 0);
        rd(2'd1, b); chk("R12 word lo", 32'(b), 32'h5A);
        rd(2'd1, b); chk("R12 word hi", 32'(b), 32'hA5);

        // R1: control port reads zero
        rd(2'd3, b); chk("R1 ctl read", 32'(b), 0);

        // R2: every mode value on every channel
        for (int ch = 0; ch < 3; ch++) begin
            for (int m = 0; m < 8; m++) begin
                ctl(ch, 1 + (m % 3), m, m[0]);
                chk("R2 mode", 32'(ch_mode[ch*3 +: 3]), 32'(m));
                chk("R2 bcd", 32'(ch_bcd[ch]), 32'(m % 2));
            end
        end

        // R3/R4/R5/R6: load and live read per channel and access type
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc <= 3; acc++) begin
                v = 16'h1234 + 16'(ch * 16'h0101) + 16'(acc * 16'h1011);
                ctl(ch, acc, 2, 0);
                if (acc == 1) begin
                    wr(2'(ch), v[7:0]);
                    chk("R3 pulse", 32'(seen_load), 32'(1 << ch));
                    chk("R3 value", 32'(seen_val[ch*16 +: 16]), 32'({8'h00, v[7:0]}));
                    @(negedge clk);
                    chk("R3 single cycle", 32'(ch_load), 0);
                end else if (acc == 2) begin
                    wr(2'(ch), v[15:8]);
                    chk("R4 pulse", 32'(seen_load), 32'(1 << ch));
                    chk("R4 value", 32'(seen_val[ch*16 +: 16]), 32'({v[15:8], 8'h00}));
                end else begin
                    wr(2'(ch), v[7:0]);
                    chk("R5 no pulse on first", 32'(seen_load), 0);
                    wr(2'(ch), v[15:8]);
                    chk("R5 pulse", 32'(seen_load), 32'(1 << ch));
                    chk("R5 value", 32'(seen_val[ch*16 +: 16]), 32'(v));
                end
                live[ch] = v ^ 16'h5A5A;
                rd(2'(ch), b);
                chk("R6 first", 32'(b), 32'(acc == 2 ? live[ch][15:8] : live[ch][7:0]));
                rd(2'(ch), b);
                chk("R6 second", 32'(b), 32'(acc == 1 ? live[ch][7:0] : live[ch][15:8]));
                rd(2'(ch), b);
                chk("R6 third", 32'(b), 32'(acc == 2 ? live[ch][15:8] : live[ch][7:0]));
            end
        end

        // R7/R8: word count latch, a second latch ignored while held
        ctl(0, 3, 0, 0);
        live[0] = 16'h1234;
        wr(2'd3, 8'h00);
        live[0] = 16'hABCD;
        wr(2'd3, 8'h00);
        rd(2'd0, b); chk("R8 latch kept lo", 32'(b), 32'h34);
        rd(2'd0, b); chk("R7 latch hi", 32'(b), 32'h12);
        rd(2'd0, b); chk("R7 released lo", 32'(b), 32'hCD);
        rd(2'd0, b); chk("R7 released hi", 32'(b), 32'hAB);

        // R7: single-byte latch releases after one read
        ctl(1, 2, 0, 0);
        live[1] = 16'h7788;
        wr(2'd3, 8'h40);
        live[1] = 16'h3344;
        rd(2'd1, b); chk("R7 hi latch", 32'(b), 32'h77);
        rd(2'd1, b); chk("R7 hi live", 32'(b), 32'h33);

        // R9: status before count via read-back, status held once
        ctl(2, 3, 3, 1);
        ch_out[2] = 1'b1;
        live[2] = 16'h4321;
        wr(2'd3, 8'hC8);
        ch_out[2] = 1'b0;
        live[2] = 16'h9999;
        wr(2'd3, 8'hE8);
        rd(2'd2, b); chk("R9 status", 32'(b), 32'hB7);
        rd(2'd2, b); chk("R9 count lo", 32'(b), 32'h21);
        rd(2'd2, b); chk("R9 count hi", 32'(b), 32'h43);
        rd(2'd2, b); chk("R9 live lo", 32'(b), 32'h99);
        rd(2'd2, b); chk("R9 live hi", 32'(b), 32'h99);

        // R10: read-back latches counts of channels 0 and 1 only
        ctl(0, 3, 0, 0); ctl(1, 3, 0, 0); ctl(2, 1, 0, 0);
        live[0] = 16'h0102; live[1] = 16'h0304; live[2] = 16'h0506;
        wr(2'd3, 8'hD6);
        live[0] = 16'hF0F0; live[1] = 16'hE0E0; live[2] = 16'hD0D0;
        rd(2'd2, b); chk("R10 unselected live", 32'(b), 32'hD0);
        rd(2'd1, b); chk("R10 ch1 lo", 32'(b), 32'h04);
        rd(2'd1, b); chk("R10 ch1 hi", 32'(b), 32'h03);
        rd(2'd0, b); chk("R10 ch0 lo", 32'(b), 32'h02);
        rd(2'd0, b); chk("R10 ch0 hi", 32'(b), 32'h01);
        // status only on channel 1: {out=0,0,acc=3,mode=0,bcd=0} = 0x30
        wr(2'd3, 8'hE4);
        rd(2'd1, b); chk("R10 status only", 32'(b), 32'h30);
        rd(2'd1, b); chk("R10 no count latch", 32'(b), 32'hE0);

        // R11: reconfiguration restarts byte sequencing
        ctl(0, 3, 0, 0);
        wr(2'd0, 8'h77);
        ctl(0, 3, 0, 0);
        wr(2'd0, 8'h01);
        chk("R11 no pulse after restart", 32'(seen_load), 0);
        wr(2'd0, 8'h02);
        chk("R11 value", 32'(seen_val[15:0]), 32'h0201);
        rd(2'd0, b);
        ctl(0, 3, 0, 0);
        rd(2'd0, b); chk("R11 read restart", 32'(b), 32'hF0);
        live[0] = 16'h1200;
        rd(2'd0, b); chk("R11 read hi", 32'(b), 32'h12);

        finish_run();
    end

endmodule